// File: doc/BRIEF.md
# ISA Target Cycle Controller

This block lets an add-in card answer memory and I/O cycles on an ISA-style expansion bus. It runs on a fast local clock. Every bus input is oversampled through a two-flop synchronizer, and the controller finds command edges on the synchronized copies. When BALE falls, the block holds the upper address bits (LA[23:17]). It uses that held copy to decide whether a memory cycle falls in its 16-bit window. It also reports 16-bit capability to the host straight from the live LA and SA pins, so that report is valid before a command arrives.

For each claimed cycle the controller produces the card-side signals. A read gives a one-clock read strobe, then the card's data is driven on SD until a short hold after the command ends. A write gives a one-clock write strobe once the command ends, carrying the captured SD value.

The controller chooses the cycle type from the decode:
- A 16-bit memory cycle is shortened by holding ENDXFR* low.
- An I/O cycle is stretched by pulling IOCHRDY low for a parameterized number of local clocks. The count is capped at a limit.
- An 8-bit memory cycle runs with normal timing.

Cycles seen with AEN high or with REFRESH* low are ignored.

Top module: `isa_target_ctrl`

## Requirements
- R1: The upper address is held on the falling edge of the synchronized BALE. The 16-bit memory window test uses that held value: a window hit is still claimed, and the other address gives no hit, even if LA changes after BALE falls and before the command.
- R2: `bus_memcs16_n` is low exactly when the live `bus_la` equals MEM16_LA (default 7'h06). `bus_iocs16_n` is low exactly when IO16_EN is set and the live `bus_sa[15:3]` matches IO_BASE (default 0x300..0x307). Both are combinational.
- R3: A memory command is claimed when the held LA equals MEM16_LA, or when SA[19:14] equals MEM8_BASE[19:14] (default 0xE8000..0xEBFFF). An I/O command is claimed when SA[15:3] matches IO_BASE. Any other command produces no strobe.
- R4: A command that starts while the synchronized AEN is high, or while the synchronized REFRESH* is low, is ignored. It produces no read strobe, no write strobe, no SD drive, no IOCHRDY pull and no ENDXFR*.
- R5: On a claimed read, `card_rd` is high for exactly one clock, with `card_addr` equal to SA. `bus_sd_out` then carries the `card_rdata` value sampled in the following clock, with `bus_sd_oe` high.
- R6: After a claimed read command is released at the pins, `bus_sd_oe` stays high for HOLD_CLKS+2 more local clocks (two synchronizer stages plus the hold) and then goes low.
- R7: On a claimed write, `card_wr` is high for exactly one clock, after the command is released. `card_wdata` equals the SD value present during the command, and `card_addr` equals SA.
- R8: The byte lanes follow {SBHE*,SA0}: 00 gives `card_be`=2'b11 (word), 01 gives 2'b10 (high byte), 10 gives 2'b01 (low byte), 11 gives 2'b01 (odd byte on the low lane). `card_be` is never 2'b00.
- R9: `bus_endxfr_n` is low only during claimed 16-bit-window memory cycles. It goes low with the cycle start and returns high three local clocks after the command is released. IOCHRDY and ENDXFR* are never active together.
- R10: On a claimed I/O cycle, `bus_iochrdy_low` is high for exactly WAIT_EFF consecutive local clocks, starting at the cycle start. It is never high when WAIT_EFF is 0, and never high on memory cycles.
- R11: WAIT_EFF is the smaller of WAIT_CLKS and MAX_LOW, so a large WAIT_CLKS yields exactly MAX_LOW pull-low clocks.
- R12: From a command being asserted at the pins, `card_rd` rises on the third rising clock edge (two synchronizer stages plus the state register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_la | input | 7 | Upper address LA[23:17] |
| bus_sa | input | 20 | System address SA[19:0] |
| bus_sbhe_n | input | 1 | High byte enable, active low |
| bus_bale | input | 1 | Address latch enable |
| bus_aen | input | 1 | DMA address enable, high means ignore |
| bus_refresh_n | input | 1 | Refresh indicator, active low |
| bus_memr_n | input | 1 | Memory read command |
| bus_memw_n | input | 1 | Memory write command |
| bus_ior_n | input | 1 | I/O read command |
| bus_iow_n | input | 1 | I/O write command |
| bus_sd_in | input | 16 | Data bus as seen from the pins |
| bus_sd_out | output | 16 | Read data to drive onto the data bus |
| bus_sd_oe | output | 1 | Data bus drive enable |
| bus_memcs16_n | output | 1 | 16-bit memory capability, active low |
| bus_iocs16_n | output | 1 | 16-bit I/O capability, active low |
| bus_iochrdy_low | output | 1 | Pull IOCHRDY low when high |
| bus_endxfr_n | output | 1 | Zero-wait-state request, active low |
| card_rd | output | 1 | Card read strobe, one clock |
| card_wr | output | 1 | Card write strobe, one clock |
| card_io | output | 1 | Current cycle is I/O space |
| card_addr | output | 20 | Cycle address |
| card_be | output | 2 | Byte lanes {high, low} |
| card_wdata | output | 16 | Write data to the card |
| card_rdata | input | 16 | Read data from the card |

## Verification
The hardest case to reach is a 16-bit memory cycle whose LA no longer points at the window by the time the command arrives. The held copy is then the only correct source for the decode. Every bench cycle therefore inverts LA a few clocks after BALE falls and before asserting the command. This separates a decoder that uses the held value from one that reads the live pins. The cap on the IOCHRDY pull is reached through a second instance built with a WAIT_CLKS far above its MAX_LOW, driven by the same stimulus.

// File: rtl/isa_tgt_pkg.sv
package isa_tgt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_ACTIVE,
        ST_HOLD
    } tgt_state_e;

    typedef enum logic [1:0] {
        CY_NORMAL,
        CY_ZWS,
        CY_EXT
    } cyc_kind_e;
endpackage

// File: rtl/isa_sync.sv
module isa_sync #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1_q <= RST_VAL[i];
                s2_q <= RST_VAL[i];
            end else begin
                s1_q <= din[i];
                s2_q <= s1_q;
            end
        end
        assign dout[i] = s2_q;
    end
endmodule

// File: rtl/isa_decode.sv
module isa_decode
    import isa_tgt_pkg::*;
#(
    parameter logic [6:0]  MEM16_LA  = 7'h06,
    parameter logic [19:0] MEM8_BASE = 20'hE8000,
    parameter int          MEM8_LSB  = 14,
    parameter logic [15:0] IO_BASE   = 16'h0300,
    parameter int          IO_LSB    = 3,
    parameter int          WAIT_EFF  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bale_s,
    input  logic [6:0]            la_s,
    input  logic [19:MEM8_LSB]    sa_hi,
    input  logic [15:IO_LSB]      sa_io,
    input  logic                  sa0,
    input  logic                  sbhe_n_s,
    input  logic                  aen_s,
    input  logic                  refresh_n_s,
    input  logic                  is_io,
    output logic                  claim,
    output cyc_kind_e             cyc,
    output logic [1:0]            be
);
    typedef struct packed {
        logic       bale_prev;
        logic [6:0] la;
    } lat_s;

    lat_s d, q;

    always_comb begin
        d = q;
        d.bale_prev = bale_s;
        if (q.bale_prev && !bale_s) d.la = la_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    logic hit16, hit8, hit_io, blocked;

    always_comb begin
        hit16   = (q.la == MEM16_LA);
        hit8    = (sa_hi == MEM8_BASE[19:MEM8_LSB]);
        hit_io  = (sa_io == IO_BASE[15:IO_LSB]);
        blocked = aen_s || !refresh_n_s;
        claim   = !blocked && (is_io ? hit_io : (hit16 || hit8));
        if (is_io)      cyc = (WAIT_EFF > 0) ? CY_EXT : CY_NORMAL;
        else if (hit16) cyc = CY_ZWS;
        else            cyc = CY_NORMAL;
        unique case ({sbhe_n_s, sa0})
            2'b00:   be = 2'b11;
            2'b01:   be = 2'b10;
            default: be = 2'b01;
        endcase
    end
endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
    import isa_tgt_pkg::*;
#(
    parameter int AW        = 20,
    parameter int DW        = 16,
    parameter int WAIT_EFF  = 4,
    parameter int HOLD_EFF  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_rd,
    input  logic          cmd_wr,
    input  logic          cmd_io,
    input  logic          claim,
    input  cyc_kind_e     cyc_in,
    input  logic [1:0]    be_in,
    input  logic [AW-1:0] sa,
    input  logic [DW-1:0] sd_in,
    input  logic [DW-1:0] card_rdata,
    output logic          card_rd,
    output logic          card_wr,
    output logic          card_io,
    output logic [AW-1:0] card_addr,
    output logic [1:0]    card_be,
    output logic [DW-1:0] card_wdata,
    output logic [DW-1:0] sd_out,
    output logic          sd_oe,
    output logic          rdy_low,
    output logic          endx
);
    localparam int CMAX = (WAIT_EFF > HOLD_EFF) ? WAIT_EFF : HOLD_EFF;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        tgt_state_e    st;
        logic          prev;
        logic          is_rd;
        logic          io;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [1:0]    be;
        logic [DW-1:0] sd_out;
        logic          oe;
        logic [DW-1:0] wcap;
        logic          card_rd;
        logic          card_wr;
        logic          rdy_low;
        logic          endx;
    } fsm_s;

    fsm_s d, q;
    logic cmd_any, fin;

    assign cmd_any = cmd_rd || cmd_wr;

    always_comb begin
        d         = q;
        fin       = 1'b0;
        d.prev    = cmd_any;
        d.card_rd = 1'b0;
        d.card_wr = 1'b0;
        if (cmd_any) d.wcap = sd_in;
        if (q.rdy_low) begin
            d.cnt = q.cnt - CW'(1);
            if (q.cnt == CW'(1)) d.rdy_low = 1'b0;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_any && !q.prev && claim) begin
                    d.addr  = sa;
                    d.be    = be_in;
                    d.io    = cmd_io;
                    d.is_rd = cmd_rd;
                    d.endx  = (cyc_in == CY_ZWS);
                    if (cyc_in == CY_EXT) begin
                        d.rdy_low = 1'b1;
                        d.cnt     = CW'(WAIT_EFF);
                    end
                    if (cmd_rd) begin
                        d.card_rd = 1'b1;
                        d.st      = ST_FETCH;
                    end else begin
                        d.st      = ST_ACTIVE;
                    end
                end
            end
            ST_FETCH: begin
                d.sd_out = card_rdata;
                d.oe     = 1'b1;
                d.st     = ST_ACTIVE;
                fin      = !cmd_any;
            end
            ST_ACTIVE: fin = !cmd_any;
            ST_HOLD: begin
                d.cnt = q.cnt - CW'(1);
                if (q.cnt == CW'(1)) begin
                    d.oe = 1'b0;
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (fin) begin
            d.rdy_low = 1'b0;
            d.endx    = 1'b0;
            if (q.is_rd) begin
                d.st  = ST_HOLD;
                d.cnt = CW'(HOLD_EFF);
            end else begin
                d.card_wr = 1'b1;
                d.st      = ST_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign card_rd    = q.card_rd;
    assign card_wr    = q.card_wr;
    assign card_io    = q.io;
    assign card_addr  = q.addr;
    assign card_be    = q.be;
    assign card_wdata = q.wcap;
    assign sd_out     = q.sd_out;
    assign sd_oe      = q.oe;
    assign rdy_low    = q.rdy_low;
    assign endx       = q.endx;

    logic [CW:0] low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      low_run_q <= '0;
        else if (!rdy_low)               low_run_q <= '0;
        else if (low_run_q != '1)        low_run_q <= low_run_q + 1'b1;
    end

    // R11
    wait_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(low_run_q) <= WAIT_EFF);

    // R9
    rdy_endx_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rdy_low && endx));

    // R5
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rd |=> !card_rd);

    // R7
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_wr |=> !card_wr);

    // R5
    rd_then_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rd |=> sd_oe);
endmodule

// File: rtl/isa_target_ctrl.sv
module isa_target_ctrl
    import isa_tgt_pkg::*;
#(
    parameter logic [6:0]  MEM16_LA  = 7'h06,
    parameter logic [19:0] MEM8_BASE = 20'hE8000,
    parameter int          MEM8_LSB  = 14,
    parameter logic [15:0] IO_BASE   = 16'h0300,
    parameter int          IO_LSB    = 3,
    parameter bit          IO16_EN   = 1'b1,
    parameter int          WAIT_CLKS = 4,
    parameter int          MAX_LOW   = 3000,
    parameter int          HOLD_CLKS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [6:0]  bus_la,
    input  logic [19:0] bus_sa,
    input  logic        bus_sbhe_n,
    input  logic        bus_bale,
    input  logic        bus_aen,
    input  logic        bus_refresh_n,
    input  logic        bus_memr_n,
    input  logic        bus_memw_n,
    input  logic        bus_ior_n,
    input  logic        bus_iow_n,
    input  logic [15:0] bus_sd_in,
    output logic [15:0] bus_sd_out,
    output logic        bus_sd_oe,
    output logic        bus_memcs16_n,
    output logic        bus_iocs16_n,
    output logic        bus_iochrdy_low,
    output logic        bus_endxfr_n,
    output logic        card_rd,
    output logic        card_wr,
    output logic        card_io,
    output logic [19:0] card_addr,
    output logic [1:0]  card_be,
    output logic [15:0] card_wdata,
    input  logic [15:0] card_rdata
);
    localparam int WAIT_EFF = (WAIT_CLKS > MAX_LOW) ? MAX_LOW : WAIT_CLKS;
    localparam int HOLD_EFF = (HOLD_CLKS < 1) ? 1 : HOLD_CLKS;
    localparam int SW       = 7 + 20 + 8 + 16;
    localparam logic [SW-1:0] SYNC_RST =
        {7'd0, 20'd0, 1'b1, 1'b0, 1'b1, 1'b1, 4'hF, 16'd0};

    logic [SW-1:0] raw_v, syn_v;
    logic [6:0]  la_s;
    logic [19:0] sa_s;
    logic        sbhe_n_s, bale_s, aen_s, refresh_n_s;
    logic        memr_n_s, memw_n_s, ior_n_s, iow_n_s;
    logic [15:0] sd_s;

    assign raw_v = {bus_la, bus_sa, bus_sbhe_n, bus_bale, bus_aen, bus_refresh_n,
                    bus_memr_n, bus_memw_n, bus_ior_n, bus_iow_n, bus_sd_in};

    isa_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_v),
        .dout (syn_v)
    );

    assign {la_s, sa_s, sbhe_n_s, bale_s, aen_s, refresh_n_s,
            memr_n_s, memw_n_s, ior_n_s, iow_n_s, sd_s} = syn_v;

    assign bus_memcs16_n = !(bus_la == MEM16_LA);
    assign bus_iocs16_n  = !(IO16_EN && (bus_sa[15:IO_LSB] == IO_BASE[15:IO_LSB]));

    logic      is_io, claim;
    cyc_kind_e cyc;
    logic [1:0] be;

    assign is_io = !ior_n_s || !iow_n_s;

    isa_decode #(
        .MEM16_LA (MEM16_LA),
        .MEM8_BASE(MEM8_BASE),
        .MEM8_LSB (MEM8_LSB),
        .IO_BASE  (IO_BASE),
        .IO_LSB   (IO_LSB),
        .WAIT_EFF (WAIT_EFF)
    ) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .bale_s     (bale_s),
        .la_s       (la_s),
        .sa_hi      (sa_s[19:MEM8_LSB]),
        .sa_io      (sa_s[15:IO_LSB]),
        .sa0        (sa_s[0]),
        .sbhe_n_s   (sbhe_n_s),
        .aen_s      (aen_s),
        .refresh_n_s(refresh_n_s),
        .is_io      (is_io),
        .claim      (claim),
        .cyc        (cyc),
        .be         (be)
    );

    logic endx;

    isa_cycle_fsm #(
        .AW      (20),
        .DW      (16),
        .WAIT_EFF(WAIT_EFF),
        .HOLD_EFF(HOLD_EFF)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_rd    (!memr_n_s || !ior_n_s),
        .cmd_wr    (!memw_n_s || !iow_n_s),
        .cmd_io    (is_io),
        .claim     (claim),
        .cyc_in    (cyc),
        .be_in     (be),
        .sa        (sa_s),
        .sd_in     (sd_s),
        .card_rdata(card_rdata),
        .card_rd   (card_rd),
        .card_wr   (card_wr),
        .card_io   (card_io),
        .card_addr (card_addr),
        .card_be   (card_be),
        .card_wdata(card_wdata),
        .sd_out    (bus_sd_out),
        .sd_oe     (bus_sd_oe),
        .rdy_low   (bus_iochrdy_low),
        .endx      (endx)
    );

    assign bus_endxfr_n = !endx;

    // R4
    ignore_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rd) |-> (!$past(aen_s) && $past(refresh_n_s)));

    // R8
    be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (card_rd || card_wr) |-> (card_be != 2'b00));

    // R10
    rdy_io_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_iochrdy_low |-> card_io);
endmodule

// File: tb/tb_isa_target_ctrl.sv
module tb_isa_target_ctrl;
    localparam int WAIT = 6;
    localparam int HOLD = 3;
    localparam int CAPW = 40;
    localparam int CAPL = 9;
    localparam int CMD_CLKS = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [6:0]  la;
    logic [19:0] sa;
    logic        sbhe_n, bale, aen, refresh_n, memr_n, memw_n, ior_n, iow_n;
    logic [15:0] sd_in;

    logic [15:0] sd_out, card_wdata, card_rdata;
    logic        sd_oe, memcs16_n, iocs16_n, rdy_low, endxfr_n;
    logic        card_rd, card_wr, card_io;
    logic [19:0] card_addr;
    logic [1:0]  card_be;

    logic [15:0] c_sd_out, c_wdata;
    logic        c_oe, c_mcs, c_ics, c_rdy, c_endx, c_rd, c_wr, c_io;
    logic [19:0] c_addr;
    logic [1:0]  c_be;

    assign card_rdata = card_addr[15:0] ^ 16'h5AC3;

    isa_target_ctrl #(.WAIT_CLKS(WAIT), .HOLD_CLKS(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .bus_la(la), .bus_sa(sa), .bus_sbhe_n(sbhe_n),
        .bus_bale(bale), .bus_aen(aen), .bus_refresh_n(refresh_n),
        .bus_memr_n(memr_n), .bus_memw_n(memw_n), .bus_ior_n(ior_n), .bus_iow_n(iow_n),
        .bus_sd_in(sd_in), .bus_sd_out(sd_out), .bus_sd_oe(sd_oe),
        .bus_memcs16_n(memcs16_n), .bus_iocs16_n(iocs16_n),
        .bus_iochrdy_low(rdy_low), .bus_endxfr_n(endxfr_n),
        .card_rd(card_rd), .card_wr(card_wr), .card_io(card_io), .card_addr(card_addr),
        .card_be(card_be), .card_wdata(card_wdata), .card_rdata(card_rdata));

    isa_target_ctrl #(.WAIT_CLKS(CAPW), .MAX_LOW(CAPL), .HOLD_CLKS(HOLD)) dut_cap (
        .clk(clk), .rst_n(rst_n), .bus_la(la), .bus_sa(sa), .bus_sbhe_n(sbhe_n),
        .bus_bale(bale), .bus_aen(aen), .bus_refresh_n(refresh_n),
        .bus_memr_n(memr_n), .bus_memw_n(memw_n), .bus_ior_n(ior_n), .bus_iow_n(iow_n),
        .bus_sd_in(sd_in), .bus_sd_out(c_sd_out), .bus_sd_oe(c_oe),
        .bus_memcs16_n(c_mcs), .bus_iocs16_n(c_ics),
        .bus_iochrdy_low(c_rdy), .bus_endxfr_n(c_endx),
        .card_rd(c_rd), .card_wr(c_wr), .card_io(c_io), .card_addr(c_addr),
        .card_be(c_be), .card_wdata(c_wdata), .card_rdata(16'h0000));

    int checks = 0;
    int failures = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic f_mem16(input logic [6:0] l);
        return l == 7'h06;
    endfunction
    function automatic logic f_mem8(input logic [19:0] a);
        return a[19:14] == 6'h3A;
    endfunction
    function automatic logic f_io(input logic [19:0] a);
        return a[15:3] == 13'h0060;
    endfunction
    function automatic logic [1:0] f_be(input logic hb_n, input logic a0);
        case ({hb_n, a0})
            2'b00:   return 2'b11;
            2'b01:   return 2'b10;
            default: return 2'b01;
        endcase
    endfunction

    // One full bus cycle; kind: 0 mem16, 1 mem8, 2 io, 3 miss, 4 aen high, 5 refresh low
    task automatic bus_cycle(input int kind, input logic is_rd, input logic [19:0] a,
                             input logic hb_n, input logic [15:0] wd);
        logic [6:0] l;
        logic is_io, clm, x16;
        int rd_n, rd_at, wr_n, rdy_n, cap_n, endx_in, endx_post, oe_post, wr_at_ok;
        logic [19:0] got_addr; logic [1:0] got_be; logic [15:0] got_sd; logic got_oe;
        logic [15:0] got_wd; logic [19:0] got_waddr;
        is_io = (kind == 2);
        l = (kind == 0 || kind >= 4) ? 7'h06 : (kind == 1 ? 7'h07 : 7'h10);
        clm = (kind <= 2) && (is_io ? f_io(a) : (f_mem16(l) || f_mem8(a)));
        x16 = clm && !is_io && f_mem16(l);
        @(negedge clk);
        la = l; sa = a; sbhe_n = hb_n; sd_in = wd;
        aen = (kind == 4); refresh_n = (kind != 5); bale = 1'b1;
        @(negedge clk);
        check("R2 memcs16", {31'd0, memcs16_n}, {31'd0, !f_mem16(l)});
        check("R2 iocs16", {31'd0, iocs16_n}, {31'd0, !f_io(a)});
        repeat (2) @(negedge clk);
        bale = 1'b0;
        repeat (4) @(negedge clk);
        la = l ^ 7'h7F;  // R1: LA no longer valid by command time
        @(negedge clk);
        check("R2 memcs16 live", {31'd0, memcs16_n}, {31'd0, !f_mem16(l ^ 7'h7F)});
        if (is_io) begin ior_n = !is_rd; iow_n = is_rd; end
        else       begin memr_n = !is_rd; memw_n = is_rd; end
        rd_n = 0; rd_at = 0; wr_n = 0; rdy_n = 0; cap_n = 0; endx_in = 0;
        endx_post = 0; oe_post = 0; got_addr = '0; got_be = '0; got_sd = '0; got_oe = 0;
        got_wd = '0; got_waddr = '0; wr_at_ok = 0;
        for (int k = 1; k <= CMD_CLKS; k++) begin
            @(negedge clk);
            if (card_rd) begin rd_n++; rd_at = k; got_addr = card_addr; got_be = card_be; end
            if (card_wr) wr_n++;
            if (rdy_low) rdy_n++;
            if (c_rdy) cap_n++;
            if (!endxfr_n) endx_in++;
            if (k == 10) begin got_oe = sd_oe; got_sd = sd_out; end
        end
        memr_n = 1'b1; memw_n = 1'b1; ior_n = 1'b1; iow_n = 1'b1;
        for (int k = 1; k <= 15; k++) begin
            @(negedge clk);
            if (sd_oe) oe_post++;
            if (!endxfr_n) endx_post++;
            if (rdy_low) rdy_n++;
            if (c_rdy) cap_n++;
            if (card_rd) rd_n++;
            if (card_wr) begin
                wr_n++; got_wd = card_wdata; got_waddr = card_addr; got_be = card_be;
                if (k == 3) wr_at_ok = 1;
            end
        end
        if (kind >= 3) check("R4 no strobes", rd_n + wr_n + rdy_n + endx_in + oe_post, 0);
        else if (kind <= 1) check("R3 mem claim", rd_n + wr_n, 1);
        else check("R3 io claim", rd_n + wr_n, clm ? 1 : 0);
        if (clm && is_rd) begin
            check("R5 rd pulses", rd_n, 1);
            check("R12 rd latency", rd_at, 3);
            check("R5 rd addr", got_addr, a);
            check("R8 rd lanes", got_be, f_be(hb_n, a[0]));
            check("R5 sd drive", {15'd0, got_oe, got_sd}, {15'd0, 1'b1, a[15:0] ^ 16'h5AC3});
            check("R6 oe hold", oe_post, HOLD + 2);
            check("R7 no wr on read", wr_n, 0);
        end
        if (clm && !is_rd) begin
            check("R7 wr pulses", wr_n, 1);
            check("R7 wr timing", wr_at_ok, 1);
            check("R7 wr data", got_wd, wd);
            check("R7 wr addr", got_waddr, a);
            check("R8 wr lanes", got_be, f_be(hb_n, a[0]));
            check("R5 no rd on write", rd_n, 0);
            check("R6 no drive on write", oe_post, 0);
        end
        if (clm) begin
            check("R9 endx during", endx_in > 0, x16);
            check("R9 endx release", endx_post, x16 ? 2 : 0);
            check("R10 iochrdy width", rdy_n, is_io ? WAIT : 0);
            check("R11 capped width", cap_n, is_io ? CAPL : 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        la = '0; sa = '0; sbhe_n = 1'b1; bale = 1'b0; aen = 1'b0; refresh_n = 1'b1;
        memr_n = 1'b1; memw_n = 1'b1; ior_n = 1'b1; iow_n = 1'b1; sd_in = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 reset rd", {31'd0, card_rd}, 0);
        check("R6 reset oe", {31'd0, sd_oe}, 0);
        check("R10 reset iochrdy", {31'd0, rdy_low}, 0);
        check("R9 reset endx", {31'd0, endxfr_n}, 1);
        // directed corners
        bus_cycle(0, 1'b1, 20'h0C124, 1'b0, 16'h0000);   // R1 16-bit read, latched LA
        bus_cycle(0, 1'b0, 20'h0D002, 1'b0, 16'hBEEF);   // R9 16-bit write
        bus_cycle(1, 1'b0, 20'hE8011, 1'b1, 16'h1234);   // R3 8-bit window write
        bus_cycle(2, 1'b1, 20'h00300, 1'b0, 16'h0000);   // R8 word
        bus_cycle(2, 1'b1, 20'h00301, 1'b0, 16'h0000);   // R8 high byte
        bus_cycle(2, 1'b1, 20'h00302, 1'b1, 16'h0000);   // R8 low byte
        bus_cycle(2, 1'b0, 20'h00307, 1'b1, 16'hA55A);   // R8 odd on low lane
        bus_cycle(2, 1'b1, 20'h00308, 1'b0, 16'h0000);   // R3 I/O miss
        bus_cycle(3, 1'b1, 20'h04000, 1'b0, 16'h0000);   // R3 memory miss
        bus_cycle(4, 1'b1, 20'h0C000, 1'b0, 16'h0000);   // R4 AEN
        bus_cycle(5, 1'b0, 20'h0C000, 1'b0, 16'h7777);   // R4 refresh
        for (int n = 0; n < 40; n++) begin
            int kind;
            logic [19:0] a;
            kind = $urandom_range(0, 5);
            a = 20'($urandom);
            if (kind == 1) a[19:14] = 6'h3A;
            if (kind == 2) a[15:3] = ($urandom_range(0, 3) == 0) ? 13'h0061 : 13'h0060;
            if (kind == 3) a[19:14] = 6'h01;
            bus_cycle(kind, 1'($urandom), a, 1'($urandom), 16'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule